// File: doc/BRIEF.md
# Pulse-Aligned Absolute Time Counter

This block keeps a local absolute time count in which one step stands for 10 ms. Software does not set the running count directly. It writes a time value ahead of an external reference pulse. The block holds that value as a pending load. When the next edge of the selected reference pulse arrives, the pending value is copied into the running count, and counting starts from that edge. After that, the count advances by one for each 10 ms tick. The tick comes either from an internal prescaler driven by the system clock or from an external 10 ms pulse.

Four raw reference signals enter the block asynchronously: a once-per-second pulse, a ten-second pulse, a 19.2 Hz square signal and a 10 ms pulse. Each passes through a two-flop synchronizer and an edge detector. A select input picks which one aligns the count. The current count is output on every cycle, so that monitor samples can be timestamped and commands can be compared against it. Two status flags are provided. One says the time is valid. The other says the alignment pulse has been missing longer than a programmable limit.

The time-value write is a valid/ready input. `set_ready_o` is always high, so the block never applies back-pressure. A transfer happens on every cycle in which `set_valid_i` is high. A newer write replaces an older pending value that has not been used yet.

Top module: `pulse_timekeeper`

## Requirements
- R1: After reset, `time_o` is 0 and `time_ok_o` and `pulse_lost_o` are 0. `time_o` stays 0 until the first alignment load, whatever the ticks do.
- R2: A write (`set_valid_i` high; `set_ready_o` is always 1) stores `set_time_i` as the pending value. It does not change `time_o`.
- R3: A raw alignment input held high across at least two clock edges is registered on the first of those edges. If a value is pending, `time_o` equals it after the third clock edge counted from that first edge. `time_ok_o` goes to 1 at the same time, and the pending value is consumed.
- R4: `align_sel_i` selects the alignment source: 0 = 1 s pulse (rising edge), 1 = 10 s pulse (rising edge), 2 = 19.2 Hz signal (both edges), 3 = 10 ms pulse (rising edge). Edges on the unselected inputs do not load the count.
- R5: An alignment edge with no pending value leaves the running count undisturbed.
- R6: With `tick_ext_i` = 0, the count rises by one every CLK_HZ/100 clock cycles. The first step comes exactly CLK_HZ/100 cycles after the load edge, because the prescaler restarts on each load.
- R7: With `tick_ext_i` = 1, the count rises by one for each rising edge of the 10 ms input, and the prescaler has no effect.
- R8: The count is 48 bits wide and wraps from 2^48-1 to 0 with no flag.
- R9: Once loaded, if no alignment edge is seen for `lost_limit_i` cycles, `pulse_lost_o` goes to 1 and `time_ok_o` goes to 0. A limit of 0 disables this check. `time_ok_o` returns to 1 only on a later load.
- R10: Any alignment edge, with or without a pending value, clears `pulse_lost_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_pulse_i | input | 1 | Raw 1 s pulse |
| dsec_pulse_i | input | 1 | Raw 10 s pulse |
| slow_sq_i | input | 1 | Raw 19.2 Hz square signal |
| cs_pulse_i | input | 1 | Raw 10 ms pulse |
| align_sel_i | input | 2 | Alignment source select |
| tick_ext_i | input | 1 | 1: tick from 10 ms input; 0: prescaler |
| lost_limit_i | input | 32 | Missing-pulse limit in cycles, 0 disables |
| set_valid_i | input | 1 | Time-value write valid |
| set_ready_o | output | 1 | Time-value write ready, always 1 |
| set_time_i | input | 48 | Time value to arm |
| time_o | output | 48 | Current absolute time in 10 ms units |
| time_ok_o | output | 1 | Time is valid |
| pulse_lost_o | output | 1 | Alignment pulse missing |

## Verification
The bench targets these corner cases:
- **Unarmed pulse.** A design that reloads a stale value on an unarmed edge makes the count jump backward.
- **Unselected source.** A pulse on an input that is not selected must not load. A design that decodes the select wrongly loads the armed value early.
- **Falling edge of the 19.2 Hz signal.** A design that detects only rising edges misses this alignment.
- **Prescaler phase.** A design that does not restart the prescaler on a load puts the first step at the wrong cycle. The bench finds this at exact sample points.
- **Wrap at the top of the 48-bit range.** A design with the wrong width or with saturation shows the wrong value there.
- **Missing-pulse limit.** A design that re-validates the time on an unarmed edge, or ignores the disable value, shows the wrong flag pattern.

// File: rtl/tk_pkg.sv
package tk_pkg;
  typedef enum logic [1:0] {
    ALIGN_SEC  = 2'd0,
    ALIGN_DSEC = 2'd1,
    ALIGN_SQ   = 2'd2,
    ALIGN_CS   = 2'd3
  } align_sel_e;

  localparam int unsigned NUM_REFS = 4;
endpackage

// File: rtl/tk_edge_sync.sv
module tk_edge_sync #(
  parameter bit BOTH_EDGES = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic edge_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  generate
    if (BOTH_EDGES) begin : g_any
      assign edge_o = sync_q ^ prev_q;
    end else begin : g_rise
      assign edge_o = sync_q & ~prev_q;
    end
  endgenerate

  // R4: a detected edge never lasts two cycles in a row
  a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/tk_tick_div.sv
module tk_tick_div #(
  parameter int unsigned DIV = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == LAST) && !restart_i;

  // R6: the phase counter never leaves its range
  a_r6_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R6: a restart suppresses the next tick for a whole period
  a_r6_restart_phase: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> cnt_q == '0);
endmodule

// File: rtl/tk_pulse_watch.sv
module tk_pulse_watch #(
  parameter int unsigned LIM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             seen_i,
  input  logic             load_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             ok_o,
  output logic             lost_o
);
  logic [LIM_W-1:0] gap_q;
  logic             expire;

  assign expire = run_i && !seen_i && (limit_i != '0) &&
                  (gap_q >= limit_i - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      ok_o   <= 1'b0;
      lost_o <= 1'b0;
    end else begin
      if (seen_i) begin
        gap_q <= '0;
      end else if (run_i && gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end

      if (seen_i) begin
        lost_o <= 1'b0;
      end else if (expire) begin
        lost_o <= 1'b1;
      end

      if (load_i) begin
        ok_o <= 1'b1;
      end else if (expire) begin
        ok_o <= 1'b0;
      end
    end
  end

  // R9: a lost pulse always withdraws validity
  a_r9_lost_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> !ok_o);
  // R10: any alignment edge clears the lost flag
  a_r10_seen_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seen_i |=> !lost_o);
  // R9: with the check disabled the flag cannot rise
  a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0) |=> !$rose(lost_o));
endmodule

// File: rtl/pulse_timekeeper.sv
module pulse_timekeeper
  import tk_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50000000,
  parameter int unsigned TIME_W = 48,
  parameter int unsigned LIM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_pulse_i,
  input  logic              dsec_pulse_i,
  input  logic              slow_sq_i,
  input  logic              cs_pulse_i,
  input  logic [1:0]        align_sel_i,
  input  logic              tick_ext_i,
  input  logic [LIM_W-1:0]  lost_limit_i,
  input  logic              set_valid_i,
  output logic              set_ready_o,
  input  logic [TIME_W-1:0] set_time_i,
  output logic [TIME_W-1:0] time_o,
  output logic              time_ok_o,
  output logic              pulse_lost_o
);
  localparam int unsigned DIV = CLK_HZ / 100;

  logic [NUM_REFS-1:0] raw_refs;
  logic [NUM_REFS-1:0] ref_edge;
  logic                align_hit, do_load, div_tick, tick;
  logic [TIME_W-1:0]   pend_q, time_q;
  logic                armed_q, running_q;
  align_sel_e          sel;

  assign raw_refs = {cs_pulse_i, slow_sq_i, dsec_pulse_i, sec_pulse_i};

  generate
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_ref
      tk_edge_sync #(.BOTH_EDGES(g == int'(ALIGN_SQ))) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_refs[g]),
        .edge_o(ref_edge[g])
      );
    end
  endgenerate

  assign sel       = align_sel_e'(align_sel_i);
  assign align_hit = ref_edge[sel];
  assign do_load   = align_hit && armed_q;

  tk_tick_div #(.DIV(DIV)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(do_load),
    .tick_o   (div_tick)
  );

  assign tick = tick_ext_i ? ref_edge[ALIGN_CS] : div_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= '0;
      armed_q   <= 1'b0;
      running_q <= 1'b0;
      time_q    <= '0;
    end else begin
      if (set_valid_i) begin
        pend_q  <= set_time_i;
        armed_q <= 1'b1;
      end else if (do_load) begin
        armed_q <= 1'b0;
      end

      if (do_load) begin
        time_q    <= pend_q;
        running_q <= 1'b1;
      end else if (running_q && tick) begin
        time_q <= time_q + 1'b1;
      end
    end
  end

  tk_pulse_watch #(.LIM_W(LIM_W)) u_watch (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (running_q),
    .seen_i (align_hit),
    .load_i (do_load),
    .limit_i(lost_limit_i),
    .ok_o   (time_ok_o),
    .lost_o (pulse_lost_o)
  );

  assign set_ready_o = 1'b1;
  assign time_o      = time_q;

  // R1: no counting before the first alignment load
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q |-> time_q == '0);
  // R3: a load takes the value that was pending
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> time_o == $past(pend_q));
  // R3: validity follows a load
  a_r3_ok_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> time_ok_o);
  // R5: without a load the count only holds or steps by one
  a_r5_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    !do_load |=> (time_o == $past(time_o)) || (time_o == $past(time_o) + 1'b1));
endmodule

// File: tb/pulse_timekeeper_tb_top.sv
module pulse_timekeeper_tb_top;
  localparam int unsigned CLK_HZ = 2000;
  localparam int unsigned DIV    = CLK_HZ / 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  refs = '0;
  logic [1:0]  align_sel = 2'd0;
  logic        tick_ext = 1'b0;
  logic [31:0] lost_limit = '0;
  logic        set_valid = 1'b0;
  logic        set_ready;
  logic [47:0] set_time = '0;
  logic [47:0] time_v;
  logic        time_ok, pulse_lost;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  longint      cyc    = 0;
  longint      lcyc   = 0;
  logic [47:0] lval   = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_timekeeper #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .sec_pulse_i(refs[0]), .dsec_pulse_i(refs[1]),
    .slow_sq_i(refs[2]), .cs_pulse_i(refs[3]),
    .align_sel_i(align_sel), .tick_ext_i(tick_ext),
    .lost_limit_i(lost_limit),
    .set_valid_i(set_valid), .set_ready_o(set_ready), .set_time_i(set_time),
    .time_o(time_v), .time_ok_o(time_ok), .pulse_lost_o(pulse_lost)
  );

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [47:0] expect_time(logic [47:0] base, longint edges);
    return base + 48'(edges / DIV);
  endfunction

  task automatic arm(logic [47:0] v);
    @(negedge clk);
    set_time  = v;
    set_valid = 1'b1;
    @(negedge clk);
    set_valid = 1'b0;
  endtask

  // drive a pulse; return at the negedge after the third sampling edge
  task automatic fire(int idx);
    @(negedge clk);
    if (idx == 2) refs[2] = ~refs[2];
    else refs[idx] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (idx != 2) refs[idx] = 1'b0;
  endtask

  task automatic fire_load(int idx, logic [47:0] v);
    fire(idx);
    lcyc = cyc;
    lval = v;
  endtask

  task automatic wait_check(string tag, int n);
    repeat (n) @(negedge clk);
    check(tag, time_v, expect_time(lval, cyc - lcyc));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [47:0] v;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 time at reset", time_v, 0);
    check("R1 ok at reset", time_ok, 0);
    check("R1 lost at reset", pulse_lost, 0);
    check("R2 ready", set_ready, 1);
    repeat (3 * DIV) @(negedge clk);
    check("R1 no count before load", time_v, 0);

    arm(48'h1234_5678);
    repeat (5) @(negedge clk);
    check("R2 pending not applied", time_v, 0);

    fire_load(0, 48'h1234_5678);
    check("R3 load value", time_v, 48'h1234_5678);
    check("R3 ok after load", time_ok, 1);
    wait_check("R6 before first step", DIV - 1);
    wait_check("R6 first step", 1);
    wait_check("R6 later", 3 * DIV + 7);

    fire(0);
    wait_check("R5 unarmed pulse", 1);
    wait_check("R5 unarmed later", DIV);

    arm(48'hABC);
    fire(1);
    wait_check("R4 unselected 10s input", 2);
    fire(2);
    wait_check("R4 unselected square input", 2);
    align_sel = 2'd1;
    fire_load(1, 48'hABC);
    check("R4 10s select load", time_v, 48'hABC);

    align_sel = 2'd2;
    arm(48'h100);
    fire_load(2, 48'h100);
    check("R4 square edge load", time_v, 48'h100);
    arm(48'h200);
    fire_load(2, 48'h200);
    check("R4 square other edge load", time_v, 48'h200);

    align_sel = 2'd3;
    arm(48'h300);
    fire_load(3, 48'h300);
    check("R4 10ms select load", time_v, 48'h300);
    wait_check("R6 after 10ms align", DIV + 3);

    align_sel = 2'd0;
    for (int i = 0; i < 10; i++) begin
      v = {16'($urandom), $urandom};
      arm(v);
      fire_load(0, v);
      check("R3 random load", time_v, v);
      wait_check("R6 random wait", int'($urandom_range(0, 6 * DIV)));
    end

    arm(48'hFFFF_FFFF_FFFE);
    fire_load(0, 48'hFFFF_FFFF_FFFE);
    wait_check("R8 wrap", 2 * DIV + 5);
    check("R8 wrap value", time_v, 48'h0);

    tick_ext = 1'b1;
    arm(48'h5000);
    fire(0);
    check("R7 load in ext mode", time_v, 48'h5000);
    repeat (3 * DIV) @(negedge clk);
    check("R7 prescaler ignored", time_v, 48'h5000);
    for (int k = 1; k <= 5; k++) begin
      fire(3);
      check("R7 external tick", time_v, 48'h5000 + 48'(k));
    end
    tick_ext = 1'b0;

    arm(48'h7000);
    fire_load(0, 48'h7000);
    lost_limit = 32'd100;
    repeat (150) @(negedge clk);
    check("R9 lost flag", pulse_lost, 1);
    check("R9 ok withdrawn", time_ok, 0);
    fire(0);
    check("R10 lost cleared", pulse_lost, 0);
    check("R9 ok stays low unarmed", time_ok, 0);
    arm(48'h7100);
    fire(0);
    check("R9 ok after reload", time_ok, 1);
    lost_limit = 32'd0;
    repeat (300) @(negedge clk);
    check("R9 disabled no lost", pulse_lost, 0);
    check("R9 disabled ok kept", time_ok, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule